// File: doc/BRIEF.md
# Ping-Pong OUT Endpoint Receive Buffer

This block stores data payloads arriving on a USB device OUT endpoint in two alternating banks. A packet engine upstream presents each decoded DATA packet as a start strobe, a stream of byte strobes and a closing strobe. The closing strobe is either a good end or an abort. The block writes the bytes into the bank whose turn it is. On a good end it marks that bank ready, records the byte count and moves to the other bank. It returns a handshake code, ACK or NAK, to the packet engine one cycle after the good end.

The CPU side reads the oldest ready bank one byte at a time through an auto-incrementing pointer. While it does so, the other bank can receive the next payload. Both banks can become ready before the CPU returns. The flags alone cannot show which bank filled first, so a single release strobe always frees the oldest ready bank. Releases therefore alternate in fill order without any help from software. An interrupt output is high while either bank is ready. A bus reset input returns the block to its empty state.

Top module: `pp_out_ep`

## Requirements
- R1: Accepted payloads fill bank 0, then bank 1, then bank 0 again, strictly alternating; a bank receives a payload only when its ready flag is clear at the packet's start strobe.
- R2: On a good end strobe for a payload of at most MAX_PKT bytes whose bank was free, the next clock edge sets that bank's ready flag, records its byte count and drives `hs_valid` high for one cycle with `hs_code` = 2'b01 (ACK).
- R3: A ready flag is cleared only by `cpu_clr` or a reset. `cpu_clr` frees the bank shown on `rel_bank` (the oldest ready bank) and then moves `rel_bank` to the other bank. `cpu_clr` has no effect while the bank on `rel_bank` is not ready.
- R4: `irq` is high exactly when at least one ready flag is set.
- R5: If the bank next in turn is still ready at the start strobe, the payload is dropped and the good end yields `hs_code` = 2'b10 (NAK). No flag, count or bank pointer changes.
- R6: A packet closed by `rx_abort` produces no handshake and no flag, and the next payload still goes to the same bank. The same holds for a packet carrying more than MAX_PKT bytes, even when it closes with a good end.
- R7: `cnt_bk0`/`cnt_bk1` show the stored byte count (0 to MAX_PKT) while the bank's flag is set, and read 0 while it is clear. A zero-length payload is accepted and gives a count of 0.
- R8: `rd_data` shows the byte at the read pointer of the bank on `rel_bank`, starting at byte 0. Each `cpu_rd` advances the pointer by one. Once the pointer reaches the count, `rd_data` reads 0 and the pointer holds. A release returns the pointer to 0.
- R9: Hardware reset and `bus_reset` clear both flags and both counts, abandon any packet in progress, and point both the fill order and `rel_bank` at bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_reset | input | 1 | Synchronous USB bus reset |
| rx_start | input | 1 | Start of an OUT DATA packet |
| rx_valid | input | 1 | Payload byte strobe |
| rx_data | input | 8 | Payload byte |
| rx_end | input | 1 | Packet ended with no error |
| rx_abort | input | 1 | Packet aborted or errored |
| hs_valid | output | 1 | Handshake code valid (one cycle) |
| hs_code | output | 2 | 01 = ACK, 10 = NAK |
| cpu_clr | input | 1 | Release the oldest ready bank |
| cpu_rd | input | 1 | Advance the read pointer |
| rd_data | output | 8 | Byte at the read pointer of the oldest ready bank |
| rel_bank | output | 1 | Bank that the next release frees |
| flag_bk0 | output | 1 | Bank 0 ready |
| flag_bk1 | output | 1 | Bank 1 ready |
| cnt_bk0 | output | 7 | Byte count of bank 0 |
| cnt_bk1 | output | 7 | Byte count of bank 1 |
| irq | output | 1 | Endpoint interrupt |

## Verification
The assertions check on every cycle that the two flags never rise together and that a flag rises only together with an ACK. They also check that a flag falls only after a release or bus reset, that a release of the ready bank on `rel_bank` clears it and flips `rel_bank`, that NAK and abort leave the flags alone, that counts stay zero on free banks, and that `irq` follows the flags. Only the bench's scenarios can show that bytes land in the right bank in order and that the read pointer walks and stops at the count. They also show that bank order survives aborts, oversize packets and NAKs, and that both banks fill and then drain in fill order.

// File: rtl/pp_ep_pkg.sv
package pp_ep_pkg;
    localparam logic [1:0] HS_NONE = 2'b00;
    localparam logic [1:0] HS_ACK  = 2'b01;
    localparam logic [1:0] HS_NAK  = 2'b10;
endpackage

// File: rtl/pp_bank_mem.sv
module pp_bank_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl
    import pp_ep_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int DW      = 8,
    parameter int CNT_W   = $clog2(MAX_PKT + 1),
    parameter int AW      = $clog2(MAX_PKT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_end,
    input  logic             rx_abort,
    input  logic [1:0]       flags,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic [1:0]       set_bk,
    output logic [CNT_W-1:0] set_cnt,
    output logic             hs_valid,
    output logic [1:0]       hs_code
);
    typedef struct packed {
        logic             active;
        logic             discard;
        logic             ovf;
        logic             bank;
        logic [CNT_W-1:0] wcnt;
        logic             hs_valid;
        logic [1:0]       hs_code;
    } fill_st_t;

    fill_st_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.hs_valid = 1'b0;
        s_d.hs_code  = HS_NONE;
        wr_en        = 1'b0;
        set_bk       = 2'b00;
        if (bus_reset) begin
            s_d = '0;
        end else if (rx_start) begin
            s_d.active  = 1'b1;
            s_d.discard = flags[s_q.bank];
            s_d.ovf     = 1'b0;
            s_d.wcnt    = '0;
        end else if (s_q.active) begin
            if (rx_abort) begin
                s_d.active = 1'b0;
            end else if (rx_end) begin
                s_d.active = 1'b0;
                if (s_q.discard) begin
                    s_d.hs_valid = 1'b1;
                    s_d.hs_code  = HS_NAK;
                end else if (!s_q.ovf) begin
                    s_d.hs_valid        = 1'b1;
                    s_d.hs_code         = HS_ACK;
                    set_bk[s_q.bank]    = 1'b1;
                    s_d.bank            = ~s_q.bank;
                end
            end else if (rx_valid && !s_q.discard) begin
                if (s_q.wcnt == CNT_W'(MAX_PKT)) begin
                    s_d.ovf = 1'b1;
                end else begin
                    wr_en    = 1'b1;
                    s_d.wcnt = s_q.wcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_bank  = s_q.bank;
    assign wr_addr  = s_q.wcnt[AW-1:0];
    assign wr_data  = rx_data;
    assign set_cnt  = s_q.wcnt;
    assign hs_valid = s_q.hs_valid;
    assign hs_code  = s_q.hs_code;
endmodule

// File: rtl/pp_rel_ctrl.sv
module pp_rel_ctrl #(
    parameter int MAX_PKT = 64,
    parameter int CNT_W   = $clog2(MAX_PKT + 1),
    parameter int AW      = $clog2(MAX_PKT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic [1:0]       set_bk,
    input  logic [CNT_W-1:0] set_cnt,
    input  logic             cpu_clr,
    input  logic             cpu_rd,
    output logic [1:0]       flags,
    output logic [CNT_W-1:0] cnt0,
    output logic [CNT_W-1:0] cnt1,
    output logic             rel_bank,
    output logic [AW-1:0]    rd_addr,
    output logic             rd_ok
);
    typedef struct packed {
        logic [1:0]            flag;
        logic [1:0][CNT_W-1:0] cnt;
        logic                  rel;
        logic [CNT_W-1:0]      rdp;
    } rel_st_t;

    rel_st_t s_d, s_q;

    always_comb begin
        rd_ok = s_q.flag[s_q.rel] && (s_q.rdp < s_q.cnt[s_q.rel]);
        s_d   = s_q;
        if (bus_reset) begin
            s_d = '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (set_bk[b]) begin
                    s_d.flag[b] = 1'b1;
                    s_d.cnt[b]  = set_cnt;
                end
            end
            if (cpu_clr && s_q.flag[s_q.rel]) begin
                s_d.flag[s_q.rel] = 1'b0;
                s_d.cnt[s_q.rel]  = '0;
                s_d.rel           = ~s_q.rel;
                s_d.rdp           = '0;
            end else if (cpu_rd && rd_ok) begin
                s_d.rdp = s_q.rdp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags    = s_q.flag;
    assign cnt0     = s_q.cnt[0];
    assign cnt1     = s_q.cnt[1];
    assign rel_bank = s_q.rel;
    assign rd_addr  = s_q.rdp[AW-1:0];
endmodule

// File: rtl/pp_out_ep.sv
module pp_out_ep #(
    parameter int MAX_PKT = 64,
    parameter int DW      = 8,
    parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_end,
    input  logic             rx_abort,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    input  logic             cpu_clr,
    input  logic             cpu_rd,
    output logic [DW-1:0]    rd_data,
    output logic             rel_bank,
    output logic             flag_bk0,
    output logic             flag_bk1,
    output logic [CNT_W-1:0] cnt_bk0,
    output logic [CNT_W-1:0] cnt_bk1,
    output logic             irq
);
    localparam int AW = $clog2(MAX_PKT);

    logic             wr_en;
    logic             wr_bank;
    logic [AW-1:0]    wr_addr;
    logic [DW-1:0]    wr_data;
    logic [1:0]       set_bk;
    logic [CNT_W-1:0] set_cnt;
    logic [1:0]       flags;
    logic [AW-1:0]    rd_addr;
    logic             rd_ok;
    logic [DW-1:0]    bank_rd [2];

    pp_fill_ctrl #(.MAX_PKT(MAX_PKT), .DW(DW), .CNT_W(CNT_W), .AW(AW)) u_fill (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_abort(rx_abort), .flags(flags),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
        .set_bk(set_bk), .set_cnt(set_cnt),
        .hs_valid(hs_valid), .hs_code(hs_code)
    );

    pp_rel_ctrl #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W), .AW(AW)) u_rel (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .set_bk(set_bk), .set_cnt(set_cnt),
        .cpu_clr(cpu_clr), .cpu_rd(cpu_rd),
        .flags(flags), .cnt0(cnt_bk0), .cnt1(cnt_bk1),
        .rel_bank(rel_bank), .rd_addr(rd_addr), .rd_ok(rd_ok)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        pp_bank_mem #(.DEPTH(MAX_PKT), .DW(DW), .AW(AW)) u_mem (
            .clk(clk),
            .wr_en(wr_en && (wr_bank == 1'(g))),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .rd_addr(rd_addr),
            .rd_data(bank_rd[g])
        );
    end

    assign rd_data  = rd_ok ? bank_rd[rel_bank] : '0;
    assign flag_bk0 = flags[0];
    assign flag_bk1 = flags[1];
    assign irq      = flags[0] | flags[1];
endmodule

// File: rtl/pp_out_ep_chk.sv
module pp_out_ep_chk #(
    parameter int MAX_PKT = 64,
    parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             rx_end,
    input logic             rx_abort,
    input logic             cpu_clr,
    input logic             hs_valid,
    input logic [1:0]       hs_code,
    input logic             rel_bank,
    input logic             flag_bk0,
    input logic             flag_bk1,
    input logic [CNT_W-1:0] cnt_bk0,
    input logic [CNT_W-1:0] cnt_bk1,
    input logic             irq
);
    assert_one_bank_per_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(flag_bk0) && $rose(flag_bk1)));

    assert_flag0_rise_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_bk0) |-> (hs_valid && hs_code == 2'b01 && $past(rx_end)));

    assert_flag1_rise_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_bk1) |-> (hs_valid && hs_code == 2'b01 && $past(rx_end)));

    assert_hs_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> (hs_code == 2'b01 || hs_code == 2'b10));

    assert_flag0_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_bk0) |-> ($past(cpu_clr) || $past(bus_reset)));

    assert_flag1_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_bk1) |-> ($past(cpu_clr) || $past(bus_reset)));

    assert_release_oldest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clr && !bus_reset && !rel_bank && flag_bk0) |=> (!flag_bk0 && rel_bank));

    assert_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (flag_bk0 || flag_bk1));

    assert_nak_no_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b10) |-> (!$rose(flag_bk0) && !$rose(flag_bk1)));

    assert_abort_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_abort) |-> (!hs_valid && !$rose(flag_bk0) && !$rose(flag_bk1)));

    assert_count_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_bk0 <= CNT_W'(MAX_PKT)) && (cnt_bk1 <= CNT_W'(MAX_PKT))
        && (flag_bk0 || cnt_bk0 == '0) && (flag_bk1 || cnt_bk1 == '0));

    assert_bus_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!flag_bk0 && !flag_bk1 && !rel_bank && !hs_valid));
endmodule

bind pp_out_ep pp_out_ep_chk #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_end(rx_end),
    .rx_abort(rx_abort), .cpu_clr(cpu_clr), .hs_valid(hs_valid),
    .hs_code(hs_code), .rel_bank(rel_bank), .flag_bk0(flag_bk0),
    .flag_bk1(flag_bk1), .cnt_bk0(cnt_bk0), .cnt_bk1(cnt_bk1), .irq(irq)
);

// File: tb/pp_out_ep_tb.sv
module pp_out_ep_tb;
    localparam int MAX   = 64;
    localparam int CNT_W = $clog2(MAX + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_reset = 1'b0;
    logic             rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_abort = 1'b0;
    logic [7:0]       rx_data = '0;
    logic             hs_valid;
    logic [1:0]       hs_code;
    logic             cpu_clr = 1'b0, cpu_rd = 1'b0;
    logic [7:0]       rd_data;
    logic             rel_bank, flag_bk0, flag_bk1, irq;
    logic [CNT_W-1:0] cnt_bk0, cnt_bk1;

    pp_out_ep #(.MAX_PKT(MAX)) u_dut (.*);

    always #10 clk = ~clk;

    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  done = 1'b0;

    logic [7:0] m_mem [2][MAX];
    int         m_cnt [2];
    bit         m_flag [2];
    int         m_fill, m_rel, m_rdp;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_rd();
        if (m_flag[m_rel] && m_rdp < m_cnt[m_rel]) return int'(m_mem[m_rel][m_rdp]);
        return 0;
    endfunction

    task automatic check_all(input string req);
        chk(req, "flag_bk0", int'(flag_bk0), int'(m_flag[0]));
        chk(req, "flag_bk1", int'(flag_bk1), int'(m_flag[1]));
        chk("R7", "cnt_bk0", int'(cnt_bk0), m_flag[0] ? m_cnt[0] : 0);
        chk("R7", "cnt_bk1", int'(cnt_bk1), m_flag[1] ? m_cnt[1] : 0);
        chk("R4", "irq", int'(irq), int'(m_flag[0] | m_flag[1]));
        chk("R3", "rel_bank", int'(rel_bank), m_rel);
        chk("R8", "rd_data", int'(rd_data), exp_rd());
    endtask

    function automatic void model_reset();
        m_flag[0] = 0; m_flag[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        m_fill = 0; m_rel = 0; m_rdp = 0;
    endfunction

    // len bytes; abort closes with rx_abort
    task automatic send_pkt(input int len, input bit abort);
        logic [7:0] bytes [MAX+2];
        int  tgt;
        bit  nak;
        tgt = m_fill;
        nak = m_flag[tgt];
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            bytes[i] = 8'($urandom);
            rx_valid = 1'b1; rx_data = bytes[i]; tick();
        end
        rx_valid = 1'b0;
        if (abort) rx_abort = 1'b1; else rx_end = 1'b1;
        tick();
        rx_abort = 1'b0; rx_end = 1'b0;
        if (nak && !abort) begin
            chk("R5", "hs_valid on NAK", int'(hs_valid), 1);
            chk("R5", "hs_code NAK", int'(hs_code), 2);
        end else if (abort || len > MAX) begin
            chk("R6", "no handshake", int'(hs_valid), 0);
        end else begin
            chk("R2", "hs_valid on ACK", int'(hs_valid), 1);
            chk("R2", "hs_code ACK", int'(hs_code), 1);
            for (int i = 0; i < len; i++) m_mem[tgt][i] = bytes[i];
            m_cnt[tgt]  = len;
            m_flag[tgt] = 1;
            m_fill      = 1 - m_fill;
        end
        check_all("R1");
    endtask

    task automatic release_bank();
        cpu_clr = 1'b1; tick(); cpu_clr = 1'b0;
        if (m_flag[m_rel]) begin
            m_flag[m_rel] = 0; m_cnt[m_rel] = 0; m_rel = 1 - m_rel; m_rdp = 0;
        end
        check_all("R3");
    endtask

    task automatic read_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            chk("R8", "rd_data", int'(rd_data), exp_rd());
            cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
            if (m_flag[m_rel] && m_rdp < m_cnt[m_rel]) m_rdp++;
        end
        check_all("R8");
    endtask

    task automatic do_bus_reset();
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        model_reset();
        chk("R9", "hs_valid after bus reset", int'(hs_valid), 0);
        check_all("R9");
    endtask

    task automatic finish_test();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_test();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check_all("R9");                       // R9 reset state

        // R1/R2: fill bank 0 then bank 1, R5: third payload NAKed
        send_pkt(5, 0);
        send_pkt(MAX, 0);                     // R7 full-size payload
        send_pkt(3, 0);                       // R5 NAK, pointer stays
        // R8: read bank 0, walk past its count
        read_bytes(7);
        release_bank();                       // R3 frees bank 0
        read_bytes(MAX);                      // R8 bank 1 contents
        send_pkt(0, 0);                       // R7 zero-length goes to bank 0
        release_bank();                       // R3 frees bank 1 (fill order)
        release_bank();                       // frees bank 0
        release_bank();                       // R3 ignored, no flag set
        // R6: abort and oversize leave pointer on bank 1
        send_pkt(4, 1);
        send_pkt(MAX + 1, 0);
        send_pkt(2, 0);                       // must land in bank 1
        read_bytes(3);
        // R9: bus reset mid-packet and with a flag set
        send_pkt(6, 0);
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        rx_valid = 1'b1; rx_data = 8'hA5; tick(); rx_valid = 1'b0;
        do_bus_reset();
        rx_end = 1'b1; tick(); rx_end = 1'b0;
        chk("R9", "no handshake for abandoned packet", int'(hs_valid), 0);
        send_pkt(1, 0);                       // R9 fills bank 0 after reset

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) begin
                int len;
                len = ($urandom_range(0, 7) == 0) ? int'($urandom_range(MAX - 1, MAX + 2))
                                                  : int'($urandom_range(0, 12));
                send_pkt(len, $urandom_range(0, 7) == 0);
            end else if (op < 7) begin
                release_bank();
            end else if (op < 9) begin
                read_bytes(int'($urandom_range(1, 6)));
            end else if ($urandom_range(0, 5) == 0) begin
                do_bus_reset();
            end else begin
                tick();
                check_all("R4");
            end
        end
        finish_test();
    end
endmodule